// File: doc/BRIEF.md
# Program Counter Sequencer

This block produces the instruction fetch address for a small 8-bit controller core. Each instruction cycle is four clock phases long, T1 to T4. Fetch and execute overlap: while one instruction executes, the next one is fetched. The program counter changes only at the end of T4, which is the instruction boundary. At that point the block picks the next address from one of these sources: the incremented value, a jump or call target, a new low byte that keeps the page bits, the top of a two-entry return stack, or one of two fixed interrupt vectors.

A transfer of control throws away the instruction that was already fetched. A satisfied conditional skip does the same. The block marks the following instruction cycle with `flush`, so the core executes a dummy cycle in that slot instead of the stale instruction. The core's decoder asserts one-hot-style control requests and holds them for the whole instruction cycle. The block samples them in T4.

A falling edge on the external interrupt pin sets a pending request, and so does a timer overflow pulse. A pending request is taken at a boundary where no live control request is present. Taking it pushes the address that was being fetched and then jumps to the vector.

Top module: `pc_sequencer`

## Requirements
- R1: While reset is held and just after it, `phase` is 0, `fetch_addr` is 0x000 and `flush` is 1. The first instruction cycle has nothing to execute.
- R2: `phase` counts 0,1,2,3 and then back to 0. `fetch_addr` changes only on the clock edge that leaves phase 3.
- R3: With no request and no interrupt taken, the address advances by one per instruction cycle, wraps modulo 2^PC_W, and `flush` is 0.
- R4: A skip request advances the address by one and sets `flush` for the next cycle. This discards the fetched instruction, so execution resumes two words after the skipping instruction.
- R5: A jump request loads `target` and sets `flush`.
- R6: A call loads `target`, sets `flush`, and pushes the current fetch address. A return loads the top entry, pops it and sets `flush`. The stack holds two entries. A push onto a full stack drops the oldest entry. Each pop repeats the deeper entry, so popping past empty keeps returning the last deep value.
- R7: A low-byte write replaces bits 7:0 of the address with `pcl_data`, keeps bits PC_W-1:8, and sets `flush`.
- R8: When several requests are present at once, the one taken follows this priority: call, then jump, then return, then low-byte write, then skip.
- R9: Requests present during an instruction cycle with `flush` = 1 are ignored. The address advances by one and `flush` returns to 0.
- R10: A high-to-low transition on `int_pin_n` makes an external request pending. It is taken at the first boundary with no live request. Taking it pushes the fetch address, loads 0x004 and sets `flush`. A boundary with a live request leaves it pending.
- R11: A `tmr_ovf` pulse makes a timer request pending. It is taken in the same way and loads 0x008. If both requests are pending, the external one is taken first and the timer request is taken at a later boundary.
- R12: A low-to-high transition on `int_pin_n`, or holding the pin low, creates no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one phase per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| int_pin_n | input | 1 | External interrupt pin, asynchronous, falling-edge active |
| tmr_ovf | input | 1 | Timer overflow pulse, one clock wide |
| req_skip | input | 1 | Skip condition satisfied |
| req_jump | input | 1 | Jump to `target` |
| req_call | input | 1 | Call `target`, pushing the return address |
| req_ret | input | 1 | Return from subroutine or interrupt |
| req_pcl_wr | input | 1 | Write `pcl_data` into the low address byte |
| pcl_data | input | 8 | New low byte for a low-byte write |
| target | input | PC_W | Address field of a jump or call |
| fetch_addr | output | PC_W | Address being fetched in this instruction cycle |
| phase | output | 2 | Current phase, 0 = T1 through 3 = T4 |
| flush | output | 1 | The instruction executing in this cycle is a dummy |

## Verification
The bench builds the block with its default width of 10 bits and vectors 0x004 and 0x008. At this width a jump to 0x3FE reaches the wrap to 0x000 within two cycles. A low-byte write from page 0x2xx shows both upper bits being kept. Three nested calls followed by three returns show the oldest entry being dropped and the deeper entry being repeated. The vectors are small enough that an interrupt-pending check against the model distinguishes the two sources.

// File: rtl/pc_sequencer.sv
module pc_sequencer #(
  parameter int PC_W    = 10,
  parameter int EXT_VEC = 4,
  parameter int TMR_VEC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            int_pin_n,
  input  logic            tmr_ovf,
  input  logic            req_skip,
  input  logic            req_jump,
  input  logic            req_call,
  input  logic            req_ret,
  input  logic            req_pcl_wr,
  input  logic [7:0]      pcl_data,
  input  logic [PC_W-1:0] target,
  output logic [PC_W-1:0] fetch_addr,
  output logic [1:0]      phase,
  output logic            flush
);
  localparam logic [PC_W-1:0] EXT_V = PC_W'(EXT_VEC);
  localparam logic [PC_W-1:0] TMR_V = PC_W'(TMR_VEC);
  localparam logic [1:0]      LAST  = 2'd3;

  logic [1:0]      ph;
  logic [PC_W-1:0] pc, stk0, stk1, pc_nx;
  logic            dmy, dmy_nx;
  logic [2:0]      pin_sync;
  logic            ext_pend, tmr_pend;

  wire boundary = (ph == LAST);
  wire pin_fall = pin_sync[2] & ~pin_sync[1];
  wire any_req  = req_call | req_jump | req_ret | req_pcl_wr | req_skip;
  wire live_req = any_req & ~dmy;
  wire take_ext = boundary & ext_pend & ~live_req;
  wire take_tmr = boundary & tmr_pend & ~ext_pend & ~live_req;
  wire do_push  = take_ext | take_tmr | (boundary & ~dmy & req_call & ~ext_pend & ~tmr_pend)
                | (boundary & ~dmy & req_call);
  wire do_pop   = boundary & ~dmy & ~req_call & ~req_jump & req_ret;

  assign fetch_addr = pc;
  assign phase      = ph;
  assign flush      = dmy;

  always_comb begin
    pc_nx  = pc + 1'b1;
    dmy_nx = 1'b0;
    if (take_ext) begin
      pc_nx  = EXT_V;
      dmy_nx = 1'b1;
    end else if (take_tmr) begin
      pc_nx  = TMR_V;
      dmy_nx = 1'b1;
    end else if (!dmy) begin
      if (req_call || req_jump) begin
        pc_nx  = target;
        dmy_nx = 1'b1;
      end else if (req_ret) begin
        pc_nx  = stk0;
        dmy_nx = 1'b1;
      end else if (req_pcl_wr) begin
        pc_nx  = {pc[PC_W-1:8], pcl_data};
        dmy_nx = 1'b1;
      end else if (req_skip) begin
        dmy_nx = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_sync <= 3'b111;
      ext_pend <= 1'b0;
      tmr_pend <= 1'b0;
    end else begin
      pin_sync <= {pin_sync[1:0], int_pin_n};
      ext_pend <= (ext_pend & ~take_ext) | pin_fall;
      tmr_pend <= (tmr_pend & ~take_tmr) | tmr_ovf;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph   <= 2'd0;
      pc   <= '0;
      dmy  <= 1'b1;
      stk0 <= '0;
      stk1 <= '0;
    end else begin
      ph <= ph + 2'd1;
      if (boundary) begin
        pc  <= pc_nx;
        dmy <= dmy_nx;
        if (do_push) begin
          stk0 <= pc;
          stk1 <= stk0;
        end else if (do_pop) begin
          stk0 <= stk1;
        end
      end
    end
  end
endmodule

module pc_sequencer_chk #(
  parameter int PC_W    = 10,
  parameter int EXT_VEC = 4,
  parameter int TMR_VEC = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_skip,
  input logic            req_jump,
  input logic            req_call,
  input logic            req_ret,
  input logic            req_pcl_wr,
  input logic [7:0]      pcl_data,
  input logic [PC_W-1:0] target,
  input logic [PC_W-1:0] fetch_addr,
  input logic [1:0]      phase,
  input logic            flush,
  input logic            ext_pend,
  input logic            tmr_pend
);
  wire any_req = req_call | req_jump | req_ret | req_pcl_wr | req_skip;
  wire t4      = (phase == 2'd3);

  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (fetch_addr == '0 && phase == 2'd0 && flush));

  a_r2_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != 2'd3) |=> (phase == $past(phase) + 2'd1));

  a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != 2'd3) |=> $stable(fetch_addr));

  a_r3_increment: assert property (@(posedge clk) disable iff (!rst_n)
    (t4 && !flush && !any_req && !ext_pend && !tmr_pend)
    |=> (fetch_addr == PC_W'($past(fetch_addr) + 1'b1) && !flush));

  a_r5_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
    (t4 && !flush && req_jump && !req_call)
    |=> (fetch_addr == $past(target) && flush));

  a_r7_page_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (t4 && !flush && req_pcl_wr && !req_call && !req_jump && !req_ret)
    |=> (fetch_addr == {$past(fetch_addr[PC_W-1:8]), $past(pcl_data)} && flush));

  a_r9_dummy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    (t4 && flush && !ext_pend && !tmr_pend)
    |=> (fetch_addr == PC_W'($past(fetch_addr) + 1'b1) && !flush));

  a_r11_ext_first: assert property (@(posedge clk) disable iff (!rst_n)
    (t4 && ext_pend && tmr_pend && (flush || !any_req))
    |=> (fetch_addr == PC_W'(EXT_VEC) && flush && tmr_pend));
endmodule

bind pc_sequencer pc_sequencer_chk #(.PC_W(PC_W), .EXT_VEC(EXT_VEC), .TMR_VEC(TMR_VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_skip(req_skip), .req_jump(req_jump),
  .req_call(req_call), .req_ret(req_ret), .req_pcl_wr(req_pcl_wr),
  .pcl_data(pcl_data), .target(target), .fetch_addr(fetch_addr),
  .phase(phase), .flush(flush), .ext_pend(ext_pend), .tmr_pend(tmr_pend)
);

// File: tb/pc_sequencer_test.sv
module pc_sequencer_test;
  localparam int W = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         int_pin_n = 1'b1;
  logic         tmr_ovf = 1'b0;
  logic         req_skip = 1'b0, req_jump = 1'b0, req_call = 1'b0, req_ret = 1'b0, req_pcl_wr = 1'b0;
  logic [7:0]   pcl_data = 8'h00;
  logic [W-1:0] target = '0;
  logic [W-1:0] fetch_addr;
  logic [1:0]   phase;
  logic         flush;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  bit keep_low = 1'b0;
  string tag = "R1";

  logic [W-1:0] m_pc = '0, m_s0 = '0, m_s1 = '0;
  logic         m_dmy = 1'b1, m_ext = 1'b0, m_tmr = 1'b0;

  pc_sequencer uut (
    .clk(clk), .rst_n(rst_n), .int_pin_n(int_pin_n), .tmr_ovf(tmr_ovf),
    .req_skip(req_skip), .req_jump(req_jump), .req_call(req_call), .req_ret(req_ret),
    .req_pcl_wr(req_pcl_wr), .pcl_data(pcl_data), .target(target),
    .fetch_addr(fetch_addr), .phase(phase), .flush(flush)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] inc(input logic [W-1:0] a);
    return a + 1'b1;
  endfunction

  task automatic cycle(input string t, input bit c, input bit j, input bit r, input bit p,
                       input bit s, input logic [7:0] d, input logic [W-1:0] tg,
                       input bit fall, input bit tov);
    logic e, tm, live;
    chk(phase == 2'd0, "R2", phase, 0);
    chk(fetch_addr == m_pc, tag, fetch_addr, m_pc);
    chk(flush == m_dmy, tag, flush, m_dmy);
    req_call = c; req_jump = j; req_ret = r; req_pcl_wr = p; req_skip = s;
    pcl_data = d; target = tg; tmr_ovf = tov;
    if (fall) int_pin_n = 1'b0;
    @(negedge clk);
    tmr_ovf = 1'b0;
    chk(phase == 2'd1 && fetch_addr == m_pc, "R2", fetch_addr, m_pc);
    @(negedge clk);
    @(negedge clk);
    chk(phase == 2'd3 && fetch_addr == m_pc, "R2", fetch_addr, m_pc);
    if (!keep_low) int_pin_n = 1'b1;
    e = m_ext | fall;
    tm = m_tmr | tov;
    live = (c | j | r | p | s) & ~m_dmy;
    if (e && !live) begin
      m_s1 = m_s0; m_s0 = m_pc; m_pc = W'(4); m_dmy = 1'b1; e = 1'b0;
    end else if (tm && !live) begin
      m_s1 = m_s0; m_s0 = m_pc; m_pc = W'(8); m_dmy = 1'b1; tm = 1'b0;
    end else if (!m_dmy && (c || j)) begin
      if (c) begin m_s1 = m_s0; m_s0 = m_pc; end
      m_pc = tg; m_dmy = 1'b1;
    end else if (!m_dmy && r) begin
      m_pc = m_s0; m_s0 = m_s1; m_dmy = 1'b1;
    end else if (!m_dmy && p) begin
      m_pc = {m_pc[W-1:8], d}; m_dmy = 1'b1;
    end else if (!m_dmy && s) begin
      m_pc = inc(m_pc); m_dmy = 1'b1;
    end else begin
      m_pc = inc(m_pc); m_dmy = 1'b0;
    end
    m_ext = e; m_tmr = tm;
    tag = t;
    @(negedge clk);
  endtask

  task automatic idle(input string t);
    cycle(t, 0, 0, 0, 0, 0, 8'h00, '0, 0, 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(fetch_addr == '0 && phase == 2'd0 && flush, "R1", fetch_addr, 0);
    rst_n = 1'b1;
    idle("R3"); idle("R3"); idle("R3");
    cycle("R4", 0, 0, 0, 0, 1, 8'h00, '0, 0, 0);
    cycle("R9", 1, 0, 0, 0, 0, 8'h00, W'(10'h155), 0, 0);
    idle("R9");
    cycle("R5", 0, 1, 0, 0, 0, 8'h00, W'(10'h3FE), 0, 0);
    idle("R3"); idle("R3"); idle("R3");
    cycle("R6", 1, 0, 0, 0, 0, 8'h00, W'(10'h100), 0, 0);
    idle("R6");
    cycle("R6", 1, 0, 0, 0, 0, 8'h00, W'(10'h200), 0, 0);
    idle("R6");
    cycle("R6", 1, 0, 0, 0, 0, 8'h00, W'(10'h300), 0, 0);
    idle("R6");
    cycle("R6", 0, 0, 1, 0, 0, 8'h00, '0, 0, 0);
    idle("R6");
    cycle("R6", 0, 0, 1, 0, 0, 8'h00, '0, 0, 0);
    idle("R6");
    cycle("R6", 0, 0, 1, 0, 0, 8'h00, '0, 0, 0);
    idle("R6");
    cycle("R5", 0, 1, 0, 0, 0, 8'h00, W'(10'h2F0), 0, 0);
    idle("R7");
    cycle("R7", 0, 0, 0, 1, 0, 8'h12, '0, 0, 0);
    idle("R7");
    cycle("R8", 1, 1, 1, 1, 1, 8'h77, W'(10'h0A0), 0, 0);
    idle("R8");
    cycle("R8", 0, 1, 1, 1, 1, 8'h77, W'(10'h0C0), 0, 0);
    idle("R8");
    cycle("R8", 0, 0, 1, 1, 1, 8'h77, '0, 0, 0);
    idle("R8");
    cycle("R8", 0, 0, 0, 1, 1, 8'h5A, '0, 0, 0);
    idle("R8");
    cycle("R10", 0, 0, 0, 0, 0, 8'h00, '0, 1, 0);
    idle("R10");
    cycle("R10", 0, 1, 0, 0, 0, 8'h00, W'(10'h040), 1, 0);
    idle("R10"); idle("R10");
    cycle("R11", 0, 0, 0, 0, 0, 8'h00, '0, 1, 1);
    idle("R11"); idle("R11");
    cycle("R11", 0, 0, 0, 0, 0, 8'h00, '0, 0, 1);
    idle("R11");
    keep_low = 1'b1;
    cycle("R12", 0, 0, 0, 0, 0, 8'h00, '0, 1, 0);
    idle("R12"); idle("R12"); idle("R12");
    keep_low = 1'b0;
    int_pin_n = 1'b1;
    idle("R12"); idle("R12"); idle("R12");
    for (int i = 0; i < 400; i++) begin
      logic [3:0] pick;
      pick = 4'($urandom_range(0, 15));
      cycle("random", pick == 1, pick == 2, pick == 3, pick == 4, pick == 5 || pick == 6,
            8'($urandom), W'($urandom), ($urandom_range(0, 9) == 0), ($urandom_range(0, 11) == 0));
    end
    idle("R3");
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule